// File: doc/BRIEF.md
# Streaming Packet Flow Statistics Monitor

This block is a passive tap on a valid/ready packet stream whose packets are framed by start-of-packet and end-of-packet markers. The stream goes straight from the input port to the output port through wires only. Nothing is registered or gated on that path, so the tap adds no latency and never stalls the stream. Alongside the stream, the monitor sorts every clock cycle by its handshake state and by whether a packet is open. It counts each of six categories in its own counter. It also keeps the data of the first few accepted beats of each packet.

When the end-of-packet beat is accepted, the counters and the stored beats are copied into a set of report registers, and a one-cycle strobe tells the consumer that a new report is there. The live counters and beat slots then clear for the next packet. The inter-packet categories count the gap in front of a packet, so each report covers the idle time before the packet and the packet itself. A one-bit configuration register turns reporting on or off. When reporting is off, the counting still goes on.

The monitor reset clears only the statistics side. The monitored stream keeps flowing while the monitor is held in reset.

Top module: `pkt_flow_mon`

## Requirements
- R1: `out_data_o`, `out_valid_o`, `out_sop_o` and `out_eop_o` equal the matching inputs, and `in_ready_o` equals `out_ready_i`, combinationally in every cycle, including while `rst_ni` is low.
- R2: Every cycle with valid and ready both high increments the transfer counter, category 0. Such a cycle counts in no other category.
- R3: A packet is open from the cycle after an accepted start-of-packet beat up to and including the cycle that accepts the end-of-packet beat. While a packet is open, valid-high/ready-low counts in category 1 (stalled), ready-high/valid-low counts in category 2 (sink waiting), and both low counts in category 3 (both idle).
- R4: While no packet is open, valid-high/ready-low counts in category 4 (gap stalled) and ready-high/valid-low counts in category 5 (gap ready). A cycle with both low is not counted.
- R5: The first NUM_CAP (default 6) accepted beats of a packet are stored. The start-of-packet beat is beat 0. Beat k is reported in `rpt_beat_o[k*DATA_W +: DATA_W]`, unfilled slots read zero, and `rpt_nbeats_o` gives the number of stored beats.
- R6: When an end-of-packet beat is accepted with reporting enabled, `rpt_valid_o` is high for exactly the next cycle. The report includes that final cycle, and category k appears in `rpt_cnt_o[k*CNT_W +: CNT_W]`. The live counters and beat slots clear, so the next report counts from the cycle after the end-of-packet beat.
- R7: The report outputs hold their value in every cycle in which `rpt_valid_o` is low.
- R8: With reporting disabled, an accepted end-of-packet beat raises no strobe and leaves the report outputs unchanged. The live counters and beat slots still clear.
- R9: Each counter saturates at its all-ones value instead of wrapping.
- R10: A cycle with `cfg_we_i` high loads `cfg_en_i` into the reporting enable, which acts from the next cycle on. The enable resets to 0.
- R11: A low `rst_ni` asynchronously clears the counters, beat slots, packet state, report outputs and the enable.
- R12: A start-of-packet beat accepted while a packet is already open restarts beat storage at beat 0. The counters carry on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous monitor reset |
| in_data_i | input | DATA_W | Stream data from the upstream source |
| in_sop_i | input | 1 | Start-of-packet marker from the source |
| in_eop_i | input | 1 | End-of-packet marker from the source |
| in_valid_i | input | 1 | Source valid |
| in_ready_o | output | 1 | Ready returned to the source |
| out_data_o | output | DATA_W | Stream data to the downstream sink |
| out_sop_o | output | 1 | Start-of-packet marker to the sink |
| out_eop_o | output | 1 | End-of-packet marker to the sink |
| out_valid_o | output | 1 | Valid to the sink |
| out_ready_i | input | 1 | Sink ready |
| cfg_we_i | input | 1 | Write strobe for the enable register |
| cfg_en_i | input | 1 | Value written to the reporting enable |
| rpt_valid_o | output | 1 | One-cycle new-report strobe |
| rpt_cnt_o | output | 6*CNT_W | Reported counters, category k at k*CNT_W |
| rpt_beat_o | output | NUM_CAP*DATA_W | Reported beats, beat k at k*DATA_W |
| rpt_nbeats_o | output | $clog2(NUM_CAP+1) | Number of stored beats in the report |

## Verification
A wrong packet-open flag or a wrong category decode changes the counter fields of the very next report, so one packet with a planned mix of stalls, waits and idle cycles shows the error when its end-of-packet beat is accepted. A live counter or beat slot that fails to clear shows up as inflated values in the report after it, and a wrong enable shows up as a missing or extra strobe one cycle after an end-of-packet beat. Any fault on the pass-through path shows on the output ports in the same cycle, whatever the monitor reset is doing.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int NUM_CAT = 6;

  typedef enum logic [2:0] {
    CAT_XFER  = 3'd0,
    CAT_BP    = 3'd1,
    CAT_SWAIT = 3'd2,
    CAT_IDLE  = 3'd3,
    CAT_IPV   = 3'd4,
    CAT_IPR   = 3'd5
  } cat_e;
endpackage

// File: rtl/pfm_classify.sv
module pfm_classify
  import pfm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               ready_i,
  input  logic               sop_i,
  input  logic               eop_i,
  output logic [NUM_CAT-1:0] inc_o,
  output logic               acc_o,
  output logic               eop_acc_o,
  output logic               open_o
);
  logic open_q;

  assign acc_o     = valid_i & ready_i;
  assign eop_acc_o = acc_o & eop_i;
  assign open_o    = open_q;

  always_comb begin
    inc_o = '0;
    if (acc_o) begin
      inc_o[CAT_XFER] = 1'b1;
    end else if (open_q) begin
      if (valid_i)      inc_o[CAT_BP]    = 1'b1;
      else if (ready_i) inc_o[CAT_SWAIT] = 1'b1;
      else              inc_o[CAT_IDLE]  = 1'b1;
    end else begin
      if (valid_i)      inc_o[CAT_IPV]   = 1'b1;
      else if (ready_i) inc_o[CAT_IPR]   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                open_q <= 1'b0;
    else if (eop_acc_o)         open_q <= 1'b0;
    else if (acc_o && sop_i)    open_q <= 1'b1;
  end
endmodule

// File: rtl/pfm_sat_ctr.sv
module pfm_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb nxt_o = (inc_i && cnt_o != MAX) ? cnt_o + ONE : cnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= nxt_o;
  end
endmodule

// File: rtl/pfm_beat_cap.sv
module pfm_beat_cap #(
  parameter int DATA_W  = 24,
  parameter int NUM_CAP = 6,
  localparam int CAP_W  = $clog2(NUM_CAP + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        acc_i,
  input  logic                        sop_i,
  input  logic                        open_i,
  input  logic                        clr_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic [NUM_CAP*DATA_W-1:0]   nxt_beats_o,
  output logic [CAP_W-1:0]            nxt_cnt_o
);
  localparam logic [CAP_W-1:0] CAP_LIM = CAP_W'(NUM_CAP);
  localparam logic [CAP_W-1:0] ONE     = CAP_W'(1);

  logic [DATA_W-1:0] slot_q [NUM_CAP];
  logic [DATA_W-1:0] slot_d [NUM_CAP];
  logic [CAP_W-1:0]  cnt_q;

  always_comb begin
    for (int k = 0; k < NUM_CAP; k++) slot_d[k] = slot_q[k];
    nxt_cnt_o = cnt_q;
    if (acc_i && sop_i) begin
      // new packet, or restart of an open one
      for (int k = 1; k < NUM_CAP; k++) slot_d[k] = '0;
      slot_d[0] = data_i;
      nxt_cnt_o = ONE;
    end else if (acc_i && open_i && cnt_q < CAP_LIM) begin
      for (int k = 0; k < NUM_CAP; k++)
        if (CAP_W'(k) == cnt_q) slot_d[k] = data_i;
      nxt_cnt_o = cnt_q + ONE;
    end
  end

  for (genvar k = 0; k < NUM_CAP; k++) begin : g_flat
    assign nxt_beats_o[k*DATA_W +: DATA_W] = slot_d[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_CAP; k++) slot_q[k] <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      for (int k = 0; k < NUM_CAP; k++) slot_q[k] <= '0;
      cnt_q <= '0;
    end else begin
      for (int k = 0; k < NUM_CAP; k++) slot_q[k] <= slot_d[k];
      cnt_q <= nxt_cnt_o;
    end
  end
endmodule

// File: rtl/pkt_flow_mon.sv
module pkt_flow_mon
  import pfm_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int CNT_W   = 32,
  parameter int NUM_CAP = 6,
  localparam int CAP_W  = $clog2(NUM_CAP + 1),
  localparam int RPT_W  = NUM_CAT * CNT_W,
  localparam int BEAT_W = NUM_CAP * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  output logic              rpt_valid_o,
  output logic [RPT_W-1:0]  rpt_cnt_o,
  output logic [BEAT_W-1:0] rpt_beat_o,
  output logic [CAP_W-1:0]  rpt_nbeats_o
);
  // stream path: wires only
  assign out_data_o  = in_data_i;
  assign out_sop_o   = in_sop_i;
  assign out_eop_o   = in_eop_i;
  assign out_valid_o = in_valid_i;
  assign in_ready_o  = out_ready_i;

  logic               en_q;
  logic [NUM_CAT-1:0] inc;
  logic               acc, eop_acc, pkt_open;
  logic [RPT_W-1:0]   live_cnt, nxt_cnt;
  logic [BEAT_W-1:0]  nxt_beats;
  logic [CAP_W-1:0]   nxt_nbeats;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (cfg_we_i) en_q <= cfg_en_i;
  end

  pfm_classify u_cls (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (in_valid_i),
    .ready_i   (out_ready_i),
    .sop_i     (in_sop_i),
    .eop_i     (in_eop_i),
    .inc_o     (inc),
    .acc_o     (acc),
    .eop_acc_o (eop_acc),
    .open_o    (pkt_open)
  );

  for (genvar k = 0; k < NUM_CAT; k++) begin : g_ctr
    pfm_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[k]),
      .clr_i  (eop_acc),
      .cnt_o  (live_cnt[k*CNT_W +: CNT_W]),
      .nxt_o  (nxt_cnt[k*CNT_W +: CNT_W])
    );
  end

  pfm_beat_cap #(.DATA_W(DATA_W), .NUM_CAP(NUM_CAP)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .sop_i       (in_sop_i),
    .open_i      (pkt_open),
    .clr_i       (eop_acc),
    .data_i      (in_data_i),
    .nxt_beats_o (nxt_beats),
    .nxt_cnt_o   (nxt_nbeats)
  );

  // report includes the end-of-packet cycle itself
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpt_valid_o  <= 1'b0;
      rpt_cnt_o    <= '0;
      rpt_beat_o   <= '0;
      rpt_nbeats_o <= '0;
    end else begin
      rpt_valid_o <= eop_acc & en_q;
      if (eop_acc && en_q) begin
        rpt_cnt_o    <= nxt_cnt;
        rpt_beat_o   <= nxt_beats;
        rpt_nbeats_o <= nxt_nbeats;
      end
    end
  end
endmodule

// File: rtl/pfm_chk.sv
module pfm_chk #(
  parameter int DATA_W  = 24,
  parameter int CNT_W   = 32,
  parameter int NUM_CAP = 6,
  parameter int NUM_CAT = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [DATA_W-1:0]         in_data_i,
  input logic                      in_sop_i,
  input logic                      in_eop_i,
  input logic                      in_valid_i,
  input logic                      in_ready_o,
  input logic [DATA_W-1:0]         out_data_o,
  input logic                      out_sop_o,
  input logic                      out_eop_o,
  input logic                      out_valid_o,
  input logic                      out_ready_i,
  input logic                      rpt_valid_o,
  input logic [NUM_CAT*CNT_W-1:0]  rpt_cnt_o,
  input logic [NUM_CAP*DATA_W-1:0] rpt_beat_o,
  input logic                      en_q,
  input logic                      eop_acc,
  input logic [NUM_CAT*CNT_W-1:0]  live_cnt
);
  a_r1_pass_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_data_o == in_data_i && out_valid_o == in_valid_i &&
    out_sop_o == in_sop_i && out_eop_o == in_eop_i);

  a_r1_pass_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o == out_ready_i);

  a_r6_strobe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> $past(in_valid_i && out_ready_i && in_eop_i));

  a_r6_live_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(eop_acc) |-> live_cnt == '0);

  a_r8_no_strobe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> $past(en_q));

  a_r7_report_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rpt_valid_o |-> ($stable(rpt_cnt_o) && $stable(rpt_beat_o)));

  for (genvar k = 0; k < NUM_CAT; k++) begin : g_sat
    a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(live_cnt[k*CNT_W +: CNT_W]) == {CNT_W{1'b1}} && !$past(eop_acc))
        |-> live_cnt[k*CNT_W +: CNT_W] == {CNT_W{1'b1}});
  end
endmodule

bind pkt_flow_mon pfm_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_CAP(NUM_CAP), .NUM_CAT(pfm_pkg::NUM_CAT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_data_i   (in_data_i),
  .in_sop_i    (in_sop_i),
  .in_eop_i    (in_eop_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_data_o  (out_data_o),
  .out_sop_o   (out_sop_o),
  .out_eop_o   (out_eop_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .rpt_valid_o (rpt_valid_o),
  .rpt_cnt_o   (rpt_cnt_o),
  .rpt_beat_o  (rpt_beat_o),
  .en_q        (en_q),
  .eop_acc     (eop_acc),
  .live_cnt    (live_cnt)
);

// File: tb/pkt_flow_mon_tb.sv
module pkt_flow_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int CW   = 4;
  localparam int NC   = 6;
  localparam int NCAT = 6;
  localparam int CMAX = (1 << CW) - 1;
  localparam int CAPW = $clog2(NC + 1);

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic [DW-1:0]   in_data_i;
  logic            in_sop_i, in_eop_i, in_valid_i, in_ready_o;
  logic [DW-1:0]   out_data_o;
  logic            out_sop_o, out_eop_o, out_valid_o, out_ready_i;
  logic            cfg_we_i, cfg_en_i;
  logic            rpt_valid_o;
  logic [NCAT*CW-1:0] rpt_cnt_o;
  logic [NC*DW-1:0]   rpt_beat_o;
  logic [CAPW-1:0]    rpt_nbeats_o;

  pkt_flow_mon #(.DATA_W(DW), .CNT_W(CW), .NUM_CAP(NC)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;

  // reference model state
  int            m_cnt [NCAT];
  logic [DW-1:0] m_q [$];
  bit            m_open, m_en;
  int            e_cnt [NCAT];
  int            e_beat [NC];
  int            e_nb;
  bit            e_rv;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NCAT; k++) begin m_cnt[k] = 0; e_cnt[k] = 0; end
    for (int k = 0; k < NC; k++) e_beat[k] = 0;
    m_q.delete();
    m_open = 0; m_en = 0; e_nb = 0; e_rv = 0;
  endtask

  function automatic int sat(input int x);
    return (x < CMAX) ? x + 1 : x;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input bit v, input bit r, input bit s, input bit e,
                     input logic [DW-1:0] d, input bit we = 0, input bit en = 0);
    bit acc;
    in_valid_i = v; out_ready_i = r; in_sop_i = s; in_eop_i = e;
    in_data_i = d; cfg_we_i = we; cfg_en_i = en;
    #1;
    chk(out_data_o == d && out_valid_o == v && out_sop_o == s &&
        out_eop_o == e && in_ready_o == r, "R1 pass-through", int'(out_data_o), int'(d));
    acc = v & r;
    e_rv = 0;
    if (acc) m_cnt[0] = sat(m_cnt[0]);
    else if (m_open) begin
      if (v) m_cnt[1] = sat(m_cnt[1]);
      else if (r) m_cnt[2] = sat(m_cnt[2]);
      else m_cnt[3] = sat(m_cnt[3]);
    end else begin
      if (v) m_cnt[4] = sat(m_cnt[4]);
      else if (r) m_cnt[5] = sat(m_cnt[5]);
    end
    if (acc && s) begin m_q.delete(); m_q.push_back(d); end
    else if (acc && m_open && m_q.size() < NC) m_q.push_back(d);
    if (acc && e) begin
      if (m_en) begin
        e_rv = 1;
        for (int k = 0; k < NCAT; k++) e_cnt[k] = m_cnt[k];
        for (int k = 0; k < NC; k++) e_beat[k] = (k < m_q.size()) ? int'(m_q[k]) : 0;
        e_nb = m_q.size();
      end
      for (int k = 0; k < NCAT; k++) m_cnt[k] = 0;
      m_q.delete();
      m_open = 0;
    end else if (acc && s) m_open = 1;
    if (we) m_en = en;
    @(posedge clk_i); #1;
    chk(rpt_valid_o == e_rv, "R6 R8 R10 strobe", int'(rpt_valid_o), int'(e_rv));
    for (int k = 0; k < NCAT; k++)
      chk(int'(rpt_cnt_o[k*CW +: CW]) == e_cnt[k], $sformatf("R2 R3 R4 R7 R9 count cat%0d", k),
          int'(rpt_cnt_o[k*CW +: CW]), e_cnt[k]);
    for (int k = 0; k < NC; k++)
      chk(int'(rpt_beat_o[k*DW +: DW]) == e_beat[k], $sformatf("R5 R12 beat%0d", k),
          int'(rpt_beat_o[k*DW +: DW]), e_beat[k]);
    chk(int'(rpt_nbeats_o) == e_nb, "R5 beat count", int'(rpt_nbeats_o), e_nb);
    @(negedge clk_i);
  endtask

  // literal expectations, independent of the model
  task automatic lit(input string tag, input int x, input int bp, input int sw,
                     input int id, input int ipv, input int ipr, input int nb);
    int ex [NCAT];
    ex = '{x, bp, sw, id, ipv, ipr};
    chk(rpt_valid_o == 1'b1, {tag, " strobe"}, int'(rpt_valid_o), 1);
    for (int k = 0; k < NCAT; k++)
      chk(int'(rpt_cnt_o[k*CW +: CW]) == ex[k], $sformatf("%s cat%0d", tag, k),
          int'(rpt_cnt_o[k*CW +: CW]), ex[k]);
    chk(int'(rpt_nbeats_o) == nb, {tag, " nbeats"}, int'(rpt_nbeats_o), nb);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    in_valid_i = 1; out_ready_i = 1; in_sop_i = 1; in_eop_i = 0; in_data_i = 8'h5A;
    cfg_we_i = 0; cfg_en_i = 0;
    #1;
    chk(out_data_o == 8'h5A && out_valid_o && out_sop_o && in_ready_o,
        "R1 pass-through in reset", int'(out_data_o), 8'h5A);
    model_reset();
    @(negedge clk_i); @(negedge clk_i);
    chk(rpt_valid_o == 0 && rpt_cnt_o == '0 && rpt_beat_o == '0 && rpt_nbeats_o == 0,
        "R11 reset state", int'(rpt_cnt_o), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int left, nlen;
    bit v, r, s, e;
    @(negedge clk_i);
    do_reset();
    @(negedge clk_i);

    // R10: enable resets to 0, so this packet gives no report
    cyc(1, 1, 1, 0, 8'h01); cyc(1, 1, 0, 1, 8'h02);
    chk(rpt_valid_o == 0, "R10 disabled after reset", int'(rpt_valid_o), 0);

    cyc(0, 0, 0, 0, 0, 1, 1);  // R10 enable; one uncounted idle gap cycle
    // R3 R4: planned mix
    cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);      // gap ready x2
    cyc(1, 0, 1, 0, 8'h10);                      // gap stalled
    cyc(1, 1, 1, 0, 8'h10);                      // sop accepted
    cyc(0, 1, 0, 0, 0);                          // sink waiting
    cyc(1, 0, 0, 0, 8'h11);                      // stalled
    cyc(0, 0, 0, 0, 0);                          // both idle
    cyc(1, 1, 0, 0, 8'h11);
    cyc(1, 1, 0, 1, 8'h12);
    lit("R3 R4 R6 mix", 3, 1, 1, 1, 1, 2, 3);

    cyc(1, 1, 1, 1, 8'h33);                      // single-beat packet
    lit("R6 single beat", 1, 0, 0, 0, 0, 0, 1);
    chk(int'(rpt_beat_o[DW +: DW]) == 0, "R5 unused slot zero", int'(rpt_beat_o[DW +: DW]), 0);

    for (int i = 0; i < 9; i++) cyc(1, 1, i == 0, i == 8, 8'(8'h40 + i));
    lit("R5 long packet", 9, 0, 0, 0, 0, 0, 6);
    chk(int'(rpt_beat_o[5*DW +: DW]) == 8'h45, "R5 last stored beat", int'(rpt_beat_o[5*DW +: DW]), 8'h45);

    cyc(0, 0, 0, 0, 0, 1, 0);                    // R8 disable
    cyc(1, 1, 1, 0, 8'h70); cyc(1, 0, 0, 0, 8'h71); cyc(1, 1, 0, 1, 8'h71);
    chk(rpt_valid_o == 0 && int'(rpt_nbeats_o) == 6, "R8 no strobe, report held", int'(rpt_nbeats_o), 6);
    cyc(0, 0, 0, 0, 0, 1, 1);
    cyc(1, 1, 1, 1, 8'h72);
    lit("R8 live cleared while disabled", 1, 0, 0, 0, 0, 0, 1);

    cyc(1, 1, 1, 0, 8'h80);                      // R9 saturation
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 8'h81);
    cyc(1, 1, 0, 1, 8'h81);
    lit("R9 saturate", 2, CMAX, 0, 0, 0, 0, 2);

    cyc(1, 1, 1, 0, 8'h01); cyc(1, 1, 0, 0, 8'h02);  // R12 restart
    cyc(1, 1, 1, 0, 8'h03); cyc(1, 1, 0, 0, 8'h04); cyc(1, 1, 0, 1, 8'h05);
    lit("R12 restart", 5, 0, 0, 0, 0, 0, 3);
    chk(int'(rpt_beat_o[0 +: DW]) == 8'h03, "R12 beat0 after restart", int'(rpt_beat_o[0 +: DW]), 8'h03);

    cyc(1, 1, 1, 0, 8'h90); cyc(1, 1, 0, 0, 8'h91);  // R11 reset mid-packet
    do_reset();
    @(negedge clk_i);
    cyc(1, 1, 0, 1, 8'h92);
    chk(rpt_valid_o == 0, "R11 enable cleared by reset", int'(rpt_valid_o), 0);

    cyc(0, 0, 0, 0, 0, 1, 1);
    left = 0;
    for (int i = 0; i < 3000; i++) begin
      v = ($urandom % 3) != 0;
      r = ($urandom % 4) != 0;
      nlen = 1 + ($urandom % 9);
      s = v && left == 0;
      e = v && ((left == 0) ? nlen == 1 : left == 1);
      cyc(v, r, s, e, 8'($urandom), ($urandom % 100) == 0, ($urandom % 4) != 0);
      if (v && r) left = s ? nlen - 1 : left - 1;
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule